// File: doc/BRIEF.md
# Three-Channel Aligned PWM Generator

This block drives three pulse-width outputs from one shared time-base counter, so all three always run at the same PWM frequency. Each channel has its own compare value, which sets its duty anywhere from fully off to fully on, and its own drive-sense bit, which says whether the load it drives is lit by a high or by a low level. A single alignment select places every channel's active pulse either at the start of each period (edge mode) or around the middle of each period (center mode).

The surrounding logic holds the configuration registers. It uses the one-clock `period_end` strobe from this block to decide when new settings may take effect. When `en` is low the counter is parked at zero and every output rests at the level that keeps its load dark.

Top module: `tri_pwm_core`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `pwm_a`, `pwm_b`, `pwm_c` and `period_end` are 0 (all outputs are registered).
- R2: When `en` is sampled low, the next clock puts each output at its dark level: 0 if its `pos_drive` bit is 1 and 1 if the bit is 0. It also drives `period_end` to 0 and returns the counter to 0 counting up.
- R3: In edge mode (`align_center` = 0) the counter runs 0, 1, …, P-1 and then wraps, where P is the effective period. A channel is active while the count is below its compare value. The output for a count appears one clock after that count is sampled, so count 0 reaches the output one clock after `en` is first sampled high.
- R4: In center mode (`align_center` = 1) the counter runs up 0…P-1 and then down P-1…0, a period of 2·P clocks. A channel is active while count + compare ≥ P, which gives one contiguous pulse of 2·compare clocks centered on the period.
- R5: A compare value of 0 keeps a channel inactive for the whole period. A compare value of P or more keeps it active for the whole period, with no inactive clock at the wrap.
- R6: `pos_drive` bit 0 belongs to `pwm_a`, bit 1 to `pwm_b` and bit 2 to `pwm_c`. When the bit is 1 the output equals the active state. When it is 0 the output is the inverse.
- R7: `period_end` is 1 for exactly the clock that follows the last count of a period. In edge mode the last count is P-1. In center mode it is the count 0 at the end of the down phase. It is never 1 unless `en` was high on the previous clock.
- R8: A `period` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low parks counter and darkens outputs |
| align_center | input | 1 | 0 = edge-aligned, 1 = center-aligned |
| period | input | CNT_W | Counts per period (P); 0 is read as 1 |
| cmp_a | input | CNT_W | Duty compare value, channel a |
| cmp_b | input | CNT_W | Duty compare value, channel b |
| cmp_c | input | CNT_W | Duty compare value, channel c |
| pos_drive | input | 3 | Drive sense per channel (bit 0 = a, 1 = b, 2 = c) |
| pwm_a | output | 1 | PWM output, channel a |
| pwm_b | output | 1 | PWM output, channel b |
| pwm_c | output | 1 | PWM output, channel c |
| period_end | output | 1 | One-clock period-boundary strobe |

## Verification
The compare logic is driven with three different compare values at once: one zero, one in the middle of the range and one at or above the period. This separates an off-by-one in the less-than test from a missing clamp at either end. The same settings run in both alignments. Center mode with a short period shows whether the turning point holds the peak count for two clocks, which decides both the pulse width and the symmetry. Mixed drive-sense patterns show whether each sense bit reaches its own channel, and a zero period together with a one-count period probes the smallest counter loop.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } count_dir_t;
endpackage

// File: rtl/tri_pwm_timebase.sv
module tri_pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  import tri_pwm_pkg::*;

  count_dir_t       dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_cnt;
  logic             at_top;

  assign top_cnt = prd - CNT_W'(1);
  assign at_top  = (cnt_q >= top_cnt);

  // last count of the current period
  always_comb begin
    if (!en)
      last = 1'b0;
    else if (center)
      last = (dir_q == DIR_DOWN) && (cnt_q == '0);
    else
      last = at_top;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!center) begin
      dir_q <= DIR_UP;
      cnt_q <= at_top ? '0 : cnt_q + CNT_W'(1);
    end else if (dir_q == DIR_UP) begin
      // the peak count is held one extra clock while turning
      if (at_top)
        dir_q <= DIR_DOWN;
      else
        cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      if (cnt_q == '0)
        dir_q <= DIR_UP;
      else
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tri_pwm_channel.sv
module tri_pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center,
  input  logic             pos,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pwm
);
  logic [CNT_W:0] sum;
  logic           act;

  assign sum = {1'b0, cnt} + {1'b0, cmp};

  always_comb begin
    if (center)
      act = (sum >= {1'b0, prd});
    else
      act = (cnt < cmp);
  end

  always_ff @(posedge clk) begin
    if (rst)
      pwm <= 1'b0;
    else if (!en)
      pwm <= ~pos;
    else
      pwm <= pos ? act : ~act;
  end
endmodule

// File: rtl/tri_pwm_core.sv
module tri_pwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             align_center,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic [2:0]       pos_drive,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             pwm_c,
  output logic             period_end
);
  import tri_pwm_pkg::*;

  logic [CNT_W-1:0] prd_eff;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic [CNT_W-1:0] cmp_arr [NUM_CH];
  logic [NUM_CH-1:0] pwm_vec;

  assign prd_eff    = (period == '0) ? CNT_W'(1) : period;
  assign cmp_arr[0] = cmp_a;
  assign cmp_arr[1] = cmp_b;
  assign cmp_arr[2] = cmp_c;

  tri_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .center (align_center),
    .prd    (prd_eff),
    .cnt    (cnt),
    .last   (last)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tri_pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .center (align_center),
      .pos    (pos_drive[g]),
      .prd    (prd_eff),
      .cnt    (cnt),
      .cmp    (cmp_arr[g]),
      .pwm    (pwm_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      period_end <= 1'b0;
    else
      period_end <= last;
  end

  assign pwm_a = pwm_vec[0];
  assign pwm_b = pwm_vec[1];
  assign pwm_c = pwm_vec[2];
endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             align_center,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cmp_a,
  input logic [2:0]       pos_drive,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             pwm_c,
  input logic             period_end
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!pwm_a && !pwm_b && !pwm_c && !period_end));

  // R2
  off_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(rst)) |=> (pwm_a == !$past(pos_drive[0]) && pwm_b == !$past(pos_drive[1])
                  && pwm_c == !$past(pos_drive[2]) && !period_end));

  // R5
  zero_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !align_center && cmp_a == '0) |=> (pwm_a == !$past(pos_drive[0])));

  // R5
  full_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (en && period != '0 && cmp_a >= period && $stable(period) && !$past(rst))
      |=> (pwm_a == $past(pos_drive[0])));

  // R3
  edge_start_chk: assert property (@(posedge clk) disable iff (rst)
    (period_end && en && !align_center && cmp_a != '0) |=> (pwm_a == $past(pos_drive[0])));

  // R7
  strobe_en_chk: assert property (@(posedge clk) disable iff (rst)
    period_end |-> $past(en));
endmodule

bind tri_pwm_core tri_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .align_center (align_center),
  .period       (period),
  .cmp_a        (cmp_a),
  .pos_drive    (pos_drive),
  .pwm_a        (pwm_a),
  .pwm_b        (pwm_b),
  .pwm_c        (pwm_c),
  .period_end   (period_end)
);

// File: tb/tri_pwm_core_tb.sv
module tri_pwm_core_tb;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             align_center = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] cmp_a = '0, cmp_b = '0, cmp_c = '0;
  logic [2:0]       pos_drive = 3'b111;
  logic             pwm_a, pwm_b, pwm_c, period_end;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  tri_pwm_core #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .align_center(align_center),
    .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .pos_drive(pos_drive), .pwm_a(pwm_a), .pwm_b(pwm_b), .pwm_c(pwm_c),
    .period_end(period_end)
  );

  // behavioural reference
  int    m_cnt = 0;
  bit    m_down = 0;
  bit    exp_pwm [3] = '{0, 0, 0};
  bit    exp_end = 0;
  string exp_tag = "R1";

  function automatic bit active(int c, int cm, int p, bit ctr);
    if (ctr) return (c + cm) >= p;
    return c < cm;
  endfunction

  always @(posedge clk) begin
    int p;
    int cm [3];
    cm[0] = int'(cmp_a); cm[1] = int'(cmp_b); cm[2] = int'(cmp_c);
    p = (period == 0) ? 1 : int'(period);
    if (rst) begin
      for (int i = 0; i < 3; i++) exp_pwm[i] = 0;
      exp_end = 0; m_cnt = 0; m_down = 0; exp_tag = "R1";
    end else if (!en) begin
      for (int i = 0; i < 3; i++) exp_pwm[i] = !pos_drive[i];
      exp_end = 0; m_cnt = 0; m_down = 0; exp_tag = "R2";
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit a;
        a = active(m_cnt, cm[i], p, align_center);
        exp_pwm[i] = pos_drive[i] ? a : !a;
      end
      exp_tag = (period == 0) ? "R8" : (pos_drive != 3'b111) ? "R6" : align_center ? "R4" : "R3";
      exp_end = 0;
      if (!align_center) begin
        m_down = 0;
        if (m_cnt >= p - 1) begin m_cnt = 0; exp_end = 1; end
        else m_cnt++;
      end else if (!m_down) begin
        if (m_cnt >= p - 1) m_down = 1;
        else m_cnt++;
      end else begin
        if (m_cnt == 0) begin m_down = 0; exp_end = 1; end
        else m_cnt--;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit got [3];
      got[0] = pwm_a; got[1] = pwm_b; got[2] = pwm_c;
      for (int i = 0; i < 3; i++) begin
        checks++;
        if (got[i] !== exp_pwm[i]) begin
          errors++;
          $display("FAIL %s ch%0d pwm actual=%b expected=%b t=%0t", exp_tag, i, got[i], exp_pwm[i], $time);
        end
      end
      checks++;
      if (period_end !== exp_end) begin
        errors++;
        $display("FAIL R7 period_end actual=%b expected=%b t=%0t", period_end, exp_end, $time);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // count active clocks per channel over one full period window
  task automatic duty(int len, int ea, int eb, int ec, string tag);
    int ha = 0, hb = 0, hc = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ha += (pwm_a == pos_drive[0]); hb += (pwm_b == pos_drive[1]); hc += (pwm_c == pos_drive[2]);
    end
    checks++;
    if (ha != ea || hb != eb || hc != ec) begin
      errors++;
      $display("FAIL %s duty actual=%0d/%0d/%0d expected=%0d/%0d/%0d", tag, ha, hb, hc, ea, eb, ec);
    end
  endtask

  task automatic setup(bit ctr, int p, int a, int b, int c, logic [2:0] pd);
    en = 0; cycles(2);
    align_center = ctr; period = CNT_W'(p);
    cmp_a = CNT_W'(a); cmp_b = CNT_W'(b); cmp_c = CNT_W'(c); pos_drive = pd;
    cycles(1); en = 1; cycles(3);
  endtask

  initial begin
    cycles(3);                        // R1 covered by model during reset
    rst = 0;
    pos_drive = 3'b101;
    cycles(5);                        // R2 dark levels with mixed sense
    // R3 edge mode, R5 extremes (0 and exactly P)
    setup(0, 10, 3, 0, 10, 3'b111);
    duty(10, 3, 0, 10, "R3");
    duty(20, 6, 0, 20, "R5");
    // R5 compare above period, R6 mixed sense
    setup(0, 10, 7, 15, 1, 3'b010);
    duty(10, 7, 10, 1, "R6");
    // R4 center mode
    setup(1, 8, 2, 5, 8, 3'b111);
    duty(16, 4, 10, 16, "R4");
    setup(1, 3, 1, 0, 9, 3'b100);
    duty(6, 2, 0, 6, "R4");
    // R8 zero period in both alignments
    setup(0, 0, 1, 0, 2, 3'b111);
    duty(5, 5, 0, 5, "R8");
    setup(1, 0, 1, 0, 1, 3'b011);
    duty(4, 4, 0, 4, "R8");
    // R7 disable mid-period then restart
    setup(0, 6, 2, 4, 6, 3'b111);
    cycles(4); en = 0; cycles(3); en = 1; cycles(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule